// File: doc/BRIEF.md
# Serial Receive Character Buffer

This block sits behind the bit-level deserializer of an asynchronous serial channel. Each completed character arrives with a one-cycle strobe, together with three per-character condition flags: break, framing error and parity error. The block stores characters in a three-position queue. The deserializer's shift register acts as one more waiting stage whenever the queue is full.

A host pops characters through a read strobe. Status outputs report three conditions: data available, queue full and overrun. The status outputs also show the condition flags of the oldest stored character. Overrun is sticky and is cleared only by a dedicated error-reset command. When a character completes while the queue is full and the waiting stage is occupied, only the waiting character and its flags are dropped. The queued characters are kept.

Top module: `rx_char_buffer`

## Requirements
- R1: After reset the queue and the waiting stage are empty. `rx_ready`, `fifo_full`, `overrun`, `head_brk`, `head_fe` and `head_pe` are all 0.
- R2: Characters are read in arrival order. `rd_data` takes the popped character on the clock edge that samples `rd_en`.
- R3: A character that completes while the queue holds three entries waits in the shift-register stage. It enters the queue in the cycle a read frees a slot, and `fifo_full` stays 1 through that read.
- R4: A character that completes while the queue is full and the waiting stage is occupied sets `overrun`. The waiting character and its flags are discarded, the new character takes the waiting stage, and the queue contents are unchanged.
- R5: `overrun` stays 1 across host reads. It returns to 0 on the edge that samples `clr_err`, unless a new overrun happens in that same cycle; a new overrun wins.
- R6: `rx_ready` becomes 1 on the edge that stores a character in the queue. It returns to 0 only when a read leaves the queue empty.
- R7: `fifo_full` is 1 exactly when all three queue positions are occupied. A read with no waiting character clears it on the same edge.
- R8: A read while the queue is empty leaves `rd_data`, `rx_ready` and `fifo_full` unchanged.
- R9: `head_brk`, `head_fe` and `head_pe` show the flags stored with the oldest queued character, and are 0 when the queue is empty.
- R10: When a read and an incoming character fall in the same cycle, the read is applied first, so the new character can use the freed slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| char_valid | input | 1 | Character-complete strobe from the deserializer |
| char_data | input | DATA_W | Completed character |
| char_brk | input | 1 | Break flag of the completed character |
| char_fe | input | 1 | Framing-error flag of the completed character |
| char_pe | input | 1 | Parity-error flag of the completed character |
| rd_en | input | 1 | Host read strobe |
| clr_err | input | 1 | Error-status reset command |
| rd_data | output | DATA_W | Last character popped |
| head_brk | output | 1 | Break flag of the oldest queued character |
| head_fe | output | 1 | Framing-error flag of the oldest queued character |
| head_pe | output | 1 | Parity-error flag of the oldest queued character |
| rx_ready | output | 1 | At least one character is queued |
| fifo_full | output | 1 | All three queue positions are occupied |
| overrun | output | 1 | Sticky overrun indication |

## Verification
A corrupted pointer or count shows up at the next read. That read returns a character out of order, or one that was never sent, and the head flags no longer match the character. A wrong waiting-stage indication shows up as a lost or duplicated character, or as `fifo_full` dropping too early, one read after the queue was filled. A missed overrun decision shows up on the same edge as a wrong `overrun` output. It also shows up later, as the wrong fourth character, after the queue is drained.

// File: rtl/rx_char_buffer.sv
module rx_char_buffer #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              char_valid,
  input  logic [DATA_W-1:0] char_data,
  input  logic              char_brk,
  input  logic              char_fe,
  input  logic              char_pe,
  input  logic              rd_en,
  input  logic              clr_err,
  output logic [DATA_W-1:0] rd_data,
  output logic              head_brk,
  output logic              head_fe,
  output logic              head_pe,
  output logic              rx_ready,
  output logic              fifo_full,
  output logic              overrun
);
  localparam int EW = DATA_W + 3;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);
  localparam logic [PW-1:0] LASTP = PW'(DEPTH - 1);

  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count, cnt_p;
  logic [EW-1:0] hold_q, in_entry, push_entry;
  logic          hold_valid;
  logic          pop, room, hold_mv, direct, push, hold_load, ovr_hit;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == LASTP) ? '0 : p + 1'b1;
  endfunction

  assign in_entry   = {char_brk, char_fe, char_pe, char_data};
  assign pop        = rd_en && (count != '0);
  assign cnt_p      = count - CW'(pop);
  assign room       = cnt_p < FULLC;
  assign hold_mv    = hold_valid && room;
  assign direct     = char_valid && !hold_valid && room;
  assign push       = hold_mv || direct;
  assign push_entry = hold_valid ? hold_q : in_entry;
  assign hold_load  = char_valid && !direct;
  assign ovr_hit    = char_valid && hold_valid && !room;

  assign rx_ready  = (count != '0);
  assign fifo_full = (count == FULLC);
  assign {head_brk, head_fe, head_pe} = rx_ready ? mem[rd_ptr][EW-1:DATA_W] : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      count      <= '0;
      hold_valid <= 1'b0;
      hold_q     <= '0;
      rd_data    <= '0;
      overrun    <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (pop) begin
        rd_data <= mem[rd_ptr][DATA_W-1:0];
        rd_ptr  <= nxt(rd_ptr);
      end
      if (push) begin
        mem[wr_ptr] <= push_entry;
        wr_ptr      <= nxt(wr_ptr);
      end
      count <= cnt_p + CW'(push);
      if (hold_load) begin
        hold_valid <= 1'b1;
        hold_q     <= in_entry;
      end else if (hold_mv) begin
        hold_valid <= 1'b0;
      end
      if (ovr_hit)      overrun <= 1'b1;
      else if (clr_err) overrun <= 1'b0;
    end
  end

  p_hold_needs_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hold_valid |-> fifo_full);
  p_full_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_valid && rd_en) |=> fifo_full);
  p_overrun_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (char_valid && hold_valid && !rd_en) |=> overrun);
  p_overrun_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !clr_err) |=> overrun);
  p_ready_on_char_r6: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid |=> rx_ready);
  p_empty_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rx_ready && !char_valid) |=> ($stable(rd_data) && !rx_ready));
  p_head_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ready |-> !(head_brk || head_fe || head_pe));
endmodule

// File: tb/rx_char_buffer_tb_top.sv
module rx_char_buffer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic char_valid = 0, char_brk = 0, char_fe = 0, char_pe = 0, rd_en = 0, clr_err = 0;
  logic [DW-1:0] char_data = '0;
  logic [DW-1:0] rd_data;
  logic head_brk, head_fe, head_pe, rx_ready, fifo_full, overrun;

  int checks = 0, errors = 0;
  logic [DW+2:0] exp_q[$];
  logic [DW+2:0] pend_item;
  logic pend = 1'b0;
  logic [DW-1:0] saved;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_char_buffer #(.DATA_W(DW), .DEPTH(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .char_data(char_data),
    .char_brk(char_brk), .char_fe(char_fe), .char_pe(char_pe), .rd_en(rd_en),
    .clr_err(clr_err), .rd_data(rd_data), .head_brk(head_brk), .head_fe(head_fe),
    .head_pe(head_pe), .rx_ready(rx_ready), .fifo_full(fifo_full), .overrun(overrun));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (pend) begin
      chk("R2 read order", 32'(rd_data), 32'(pend_item[DW-1:0]));
      pend = 1'b0;
    end
    if (rd_en && rx_ready) begin
      if (exp_q.size() == 0) chk("R2 unexpected data", 1, 0);
      else begin
        pend_item = exp_q.pop_front();
        chk("R9 head flags", {29'd0, head_brk, head_fe, head_pe}, {29'd0, pend_item[DW+2:DW]});
        pend = 1'b1;
      end
    end
  end

  task automatic drive(input logic cv, input logic [DW+2:0] it, input logic rd, input logic ce);
    @(posedge clk); #(CLK_PERIOD/4);
    char_valid = cv; {char_brk, char_fe, char_pe, char_data} = it;
    rd_en = rd; clr_err = ce;
    if (cv) exp_q.push_back(it);
    @(posedge clk); #(CLK_PERIOD/4);
    char_valid = 0; rd_en = 0; clr_err = 0;
    @(negedge clk);
  endtask

  task automatic push(input logic [DW+2:0] it); drive(1, it, 0, 0); endtask
  task automatic pop();                         drive(0, '0, 1, 0); endtask

  initial begin
    #(CLK_PERIOD * 100000);
    chk("watchdog", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4) rst_n = 1;
    @(negedge clk);
    chk("R1 reset status", {26'd0, rx_ready, fifo_full, overrun, head_brk, head_fe, head_pe}, 0);

    push({3'b100, 8'hA1});
    chk("R6 ready after first char", 32'(rx_ready), 1);
    chk("R9 head break", {29'd0, head_brk, head_fe, head_pe}, 3'b100);
    push({3'b010, 8'hB2});
    chk("R7 not full at two", 32'(fifo_full), 0);
    push({3'b001, 8'hC3});
    chk("R7 full at three", 32'(fifo_full), 1);
    push({3'b011, 8'hD4});
    chk("R3 full while waiting", 32'(fifo_full), 1);
    pop();
    chk("R3 full kept after refill", 32'(fifo_full), 1);
    chk("R4 no overrun yet", 32'(overrun), 0);

    push({3'b000, 8'hE5});
    push({3'b111, 8'hF6});
    void'(exp_q.pop_back());
    void'(exp_q.pop_back());
    exp_q.push_back({3'b111, 8'hF6});
    chk("R4 overrun set", 32'(overrun), 1);
    chk("R4 queue intact head", 32'(head_fe), 1);

    pop();
    chk("R5 overrun kept after read", 32'(overrun), 1);
    chk("R3 waiting char refills", 32'(fifo_full), 1);
    pop();
    chk("R7 full cleared by read", 32'(fifo_full), 0);
    pop();
    chk("R6 ready while one left", 32'(rx_ready), 1);
    pop();
    chk("R6 ready cleared when empty", 32'(rx_ready), 0);
    chk("R9 head flags zero when empty", {29'd0, head_brk, head_fe, head_pe}, 0);
    chk("R5 overrun still set", 32'(overrun), 1);

    saved = rd_data;
    pop();
    chk("R8 empty read keeps data", 32'(rd_data), 32'(saved));
    chk("R8 empty read keeps flags", {30'd0, rx_ready, fifo_full}, 0);

    drive(0, '0, 0, 1);
    chk("R5 overrun cleared by command", 32'(overrun), 0);

    push({3'b000, 8'h11});
    drive(1, {3'b000, 8'h22}, 1, 0);
    chk("R10 one entry after pop+push", {30'd0, rx_ready, fifo_full}, 2'b10);
    push({3'b000, 8'h33});
    push({3'b000, 8'h44});
    chk("R7 full again", 32'(fifo_full), 1);
    drive(1, {3'b010, 8'h55}, 1, 0);
    chk("R10 pop first, new char stored", 32'(fifo_full), 1);
    chk("R10 no overrun on pop+push", 32'(overrun), 0);
    repeat (4) pop();
    chk("R2 all drained", 32'(exp_q.size()), 0);
    chk("R6 empty at end", 32'(rx_ready), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule